// File: doc/BRIEF.md
# Power State Arbiter

This block chooses the operating power state of a power-management controller. It watches two sleep-control bits, a trigger bit that says whether memory contents are kept during low power, an enable pin, a pending high-priority enable interrupt, and a wake pin. From these it computes a target state every cycle.

When the target differs from the current state, the block moves to it. It issues a one-cycle sequence-start pulse that names the old and new states. It then waits for a sequence-done input before it accepts any further change. The rail sequencer downstream uses that pulse to run the matching power sequence, and it reports completion through the done input.

The priority order is fixed:
- Leaving OFF needs a rising edge on the enable pin.
- Once out of OFF, a pending enable interrupt forces ACTIVE.
- Below the interrupt, the wake pin forces ACTIVE.
- Below the wake pin, the sleep-bit decode chooses the state.

State codes are OFF=0, ACTIVE=1, MCU with memory=2, MCU without memory=3, memory retention=4 and full retention=5.

Top module: `pwr_state_arb`

## Requirements
- R1: While the synchronous active-low reset is low, state_o is 0 (OFF) and seq_start is 0.
- R2: From OFF (0) the block moves to ACTIVE (1) only after a rising edge of en_pin. A high level held since reset causes no move.
- R3: Outside OFF, a high en_irq_pend selects ACTIVE (1) whatever the sleep bits, the keep bit and the wake pin are. This holds even when both sleep bits are 0.
- R4: With no interrupt and no wake, slp_a=1 and slp_b=1 select ACTIVE (1).
- R5: With slp_a=0 and slp_b=1, keep_mem=1 selects MCU with memory (2) and keep_mem=0 selects MCU without memory (3).
- R6: With slp_b=0, keep_mem=1 selects memory retention (4) and keep_mem=0 selects full retention (5), for either value of slp_a.
- R7: Outside OFF and with no interrupt, a high wake_pin selects ACTIVE (1) ahead of the sleep-bit decode.
- R8: Each state change updates state_o on the same clock edge that raises seq_start for exactly one cycle. In that cycle seq_from holds the old state and seq_to holds the new state.
- R9: After a seq_start pulse, state_o does not change until seq_done has been sampled high. A seq_done sampled while no sequence is pending has no effect.
- R10: OFF is never re-entered, and en_pin has no effect once the block has left OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slp_a | input | 1 | First sleep-control bit |
| slp_b | input | 1 | Second sleep-control bit |
| keep_mem | input | 1 | Trigger bit: 1 keeps memory retained in low power |
| en_pin | input | 1 | Enable pin, rising-edge sensitive |
| en_irq_pend | input | 1 | Pending enable interrupt, forces ACTIVE |
| wake_pin | input | 1 | Wake pin, level forces ACTIVE |
| seq_done | input | 1 | Power sequence finished |
| state_o | output | 3 | Current state code |
| seq_start | output | 1 | One-cycle sequence start pulse |
| seq_from | output | 3 | Source state of the sequence |
| seq_to | output | 3 | Destination state of the sequence |

## Verification
A wrong state register shows at state_o on the edge after the inputs that select it. Any bad move also shows as a seq_start pulse, which the scoreboard did not expect or whose from/to pair does not match. A wrong busy flag shows either as a second change before seq_done or as a missing change one edge after seq_done. A wrong priority order shows as a move away from ACTIVE while the interrupt or wake pin is high. Each of these faults becomes visible within two clock edges of the stimulus that exposes it.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;

  typedef enum logic [2:0] {
    PS_OFF       = 3'd0,
    PS_ACTIVE    = 3'd1,
    PS_MCU_MEM   = 3'd2,
    PS_MCU_NOMEM = 3'd3,
    PS_MEM_RET   = 3'd4,
    PS_RET       = 3'd5
  } pwr_state_e;

  // Sleep-bit table: both high is full power; only slp_b high keeps MCU up.
  function automatic pwr_state_e decode_sleep(logic a, logic b, logic keep);
    if (a && b)  return PS_ACTIVE;
    else if (b)  return keep ? PS_MCU_MEM : PS_MCU_NOMEM;
    else         return keep ? PS_MEM_RET : PS_RET;
  endfunction

  // Priority: OFF exit by enable edge, then interrupt, then wake, then table.
  function automatic pwr_state_e pick_target(pwr_state_e cur, logic en_rise,
                                             logic irq, logic wake,
                                             logic a, logic b, logic keep);
    if (cur == PS_OFF) return en_rise ? PS_ACTIVE : PS_OFF;
    else if (irq)      return PS_ACTIVE;
    else if (wake)     return PS_ACTIVE;
    else               return decode_sleep(a, b, keep);
  endfunction

endpackage

// File: rtl/pwr_arb_edge.sv
module pwr_arb_edge #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  // Sampled through reset too, so a level held from reset is not an edge.
  always_ff @(posedge clk) lvl_q <= lvl;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/pwr_arb_target.sv
module pwr_arb_target
  import pwr_arb_pkg::*;
(
  input  pwr_state_e cur,
  input  logic       en_rise,
  input  logic       irq,
  input  logic       wake,
  input  logic       slp_a,
  input  logic       slp_b,
  input  logic       keep_mem,
  output pwr_state_e tgt
);
  always_comb tgt = pick_target(cur, en_rise, irq, wake, slp_a, slp_b, keep_mem);
endmodule

// File: rtl/pwr_arb_seq.sv
module pwr_arb_seq
  import pwr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e tgt,
  input  logic       done,
  output pwr_state_e cur,
  output logic       busy,
  output logic       start,
  output pwr_state_e from_s,
  output pwr_state_e to_s,
  output logic       change_go
);
  assign change_go = !busy && (tgt != cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= PS_OFF;
      busy   <= 1'b0;
      start  <= 1'b0;
      from_s <= PS_OFF;
      to_s   <= PS_OFF;
    end else begin
      start <= 1'b0;
      if (busy) begin
        if (done) busy <= 1'b0;
      end else if (change_go) begin
        from_s <= cur;
        to_s   <= tgt;
        cur    <= tgt;
        start  <= 1'b1;
        busy   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_state_arb.sv
module pwr_state_arb
  import pwr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_a,
  input  logic       slp_b,
  input  logic       keep_mem,
  input  logic       en_pin,
  input  logic       en_irq_pend,
  input  logic       wake_pin,
  input  logic       seq_done,
  output logic [2:0] state_o,
  output logic       seq_start,
  output logic [2:0] seq_from,
  output logic [2:0] seq_to
);
  logic       en_rise;
  logic       seq_busy;
  logic       change_go;
  pwr_state_e cur_state, tgt_state, from_s, to_s;

  pwr_arb_edge #(.N(1)) u_edge (
    .clk  (clk),
    .lvl  (en_pin),
    .rise (en_rise)
  );

  pwr_arb_target u_tgt (
    .cur      (cur_state),
    .en_rise  (en_rise),
    .irq      (en_irq_pend),
    .wake     (wake_pin),
    .slp_a    (slp_a),
    .slp_b    (slp_b),
    .keep_mem (keep_mem),
    .tgt      (tgt_state)
  );

  pwr_arb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt       (tgt_state),
    .done      (seq_done),
    .cur       (cur_state),
    .busy      (seq_busy),
    .start     (seq_start),
    .from_s    (from_s),
    .to_s      (to_s),
    .change_go (change_go)
  );

  assign state_o  = cur_state;
  assign seq_from = from_s;
  assign seq_to   = to_s;
endmodule

// File: rtl/pwr_state_arb_chk.sv
module pwr_state_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_pin,
  input logic       en_irq_pend,
  input logic       wake_pin,
  input logic       seq_start,
  input logic [2:0] seq_from,
  input logic [2:0] seq_to,
  input logic [2:0] state_o,
  input logic       seq_busy
);
  AST_RESET_OFF: assert property (@(posedge clk) !rst_n |=> (state_o == 3'd0 && !seq_start)); // R1

  AST_OFF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !(en_pin && !$past(en_pin))) |=> state_o == 3'd0); // R2

  AST_IRQ_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && en_irq_pend) |=> state_o == 3'd1); // R3

  AST_WAKE_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && wake_pin) |=> state_o == 3'd1); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R8

  AST_PULSE_FROM_TO: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (seq_to == state_o && seq_from == $past(state_o) && seq_from != seq_to)); // R8

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(state_o)); // R9

  AST_NO_OFF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd0 |=> state_o != 3'd0); // R10

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5); // R8
endmodule

bind pwr_state_arb pwr_state_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_pin      (en_pin),
  .en_irq_pend (en_irq_pend),
  .wake_pin    (wake_pin),
  .seq_start   (seq_start),
  .seq_from    (seq_from),
  .seq_to      (seq_to),
  .state_o     (state_o),
  .seq_busy    (seq_busy)
);

// File: tb/pwr_state_arb_bench.sv
module pwr_state_arb_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, slp_a, slp_b, keep_mem, en_pin, en_irq_pend, wake_pin, seq_done;
  logic [2:0] state_o, seq_from, seq_to;
  logic seq_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [5:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_arb u_pwr_state_arb (
    .clk(clk), .rst_n(rst_n), .slp_a(slp_a), .slp_b(slp_b), .keep_mem(keep_mem),
    .en_pin(en_pin), .en_irq_pend(en_irq_pend), .wake_pin(wake_pin),
    .seq_done(seq_done), .state_o(state_o), .seq_start(seq_start),
    .seq_from(seq_from), .seq_to(seq_to)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_move(input logic [2:0] f, input logic [2:0] t);
    expq.push_back({f, t});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_seq();
    seq_done = 1'b1;
    cyc(1);
    seq_done = 1'b0;
  endtask

  // Monitor: every start pulse must match the oldest expected move (R8)
  always @(negedge clk) begin
    if (rst_n && seq_start) begin
      if (expq.size() == 0) begin
        check("R8 unexpected pulse to", int'(seq_to), 99);
      end else begin
        logic [5:0] e;
        e = expq.pop_front();
        check("R8 seq_from", int'(seq_from), int'(e[5:3]));
        check("R8 seq_to", int'(seq_to), int'(e[2:0]));
        check("R8 state_o with pulse", int'(state_o), int'(e[2:0]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check("watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; slp_a = 0; slp_b = 0; keep_mem = 0; en_pin = 1;
    en_irq_pend = 1; wake_pin = 0; seq_done = 0;
    cyc(3);
    check("R1 reset state", int'(state_o), 0);
    check("R1 reset pulse", int'(seq_start), 0);
    rst_n = 1;
    cyc(4);
    check("R2 held level no move", int'(state_o), 0);
    en_pin = 0; cyc(1);
    expect_move(3'd0, 3'd1);
    en_pin = 1; cyc(3);
    check("R2 edge to ACTIVE", int'(state_o), 1);
    finish_seq(); cyc(4);
    check("R3 irq holds ACTIVE with sleep bits 0", int'(state_o), 1);
    slp_a = 1; slp_b = 1; en_irq_pend = 0; cyc(4);
    check("R4 both bits ACTIVE", int'(state_o), 1);
    expect_move(3'd1, 3'd2);
    slp_a = 0; keep_mem = 1; cyc(3);
    check("R5 MCU with memory", int'(state_o), 2);
    keep_mem = 0; cyc(4);
    check("R9 no change before done", int'(state_o), 2);
    expect_move(3'd2, 3'd3);
    finish_seq(); cyc(3);
    check("R5 MCU without memory", int'(state_o), 3);
    finish_seq();
    expect_move(3'd3, 3'd4);
    slp_b = 0; keep_mem = 1; cyc(3);
    check("R6 memory retention", int'(state_o), 4);
    finish_seq();
    slp_a = 1; cyc(4);
    check("R6 slp_a ignored in memory retention", int'(state_o), 4);
    expect_move(3'd4, 3'd5);
    keep_mem = 0; cyc(3);
    check("R6 full retention slp_a=1", int'(state_o), 5);
    finish_seq();
    slp_a = 0; cyc(3);
    check("R6 full retention slp_a=0", int'(state_o), 5);
    expect_move(3'd5, 3'd1);
    wake_pin = 1; cyc(3);
    check("R7 wake to ACTIVE", int'(state_o), 1);
    finish_seq(); cyc(3);
    check("R7 wake holds ACTIVE", int'(state_o), 1);
    expect_move(3'd1, 3'd5);
    wake_pin = 0; cyc(3);
    check("R7 wake released back to table", int'(state_o), 5);
    finish_seq();
    expect_move(3'd5, 3'd1);
    en_irq_pend = 1; wake_pin = 1; cyc(3);
    check("R3 irq forces ACTIVE", int'(state_o), 1);
    finish_seq();
    wake_pin = 0; cyc(3);
    check("R3 irq holds over table", int'(state_o), 1);
    expect_move(3'd1, 3'd5);
    en_irq_pend = 0; cyc(3);
    check("R3 irq cleared follows table", int'(state_o), 5);
    finish_seq(); cyc(2);
    finish_seq(); cyc(3);
    check("R9 idle done no effect", int'(state_o), 5);
    en_pin = 0; cyc(2); en_pin = 1; cyc(3);
    check("R10 enable edge ignored", int'(state_o), 5);
    check("R10 not OFF", int'(state_o != 3'd0), 1);
    check("R8 all expected pulses seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule